// File: doc/BRIEF.md
# Paged Nonvolatile Write-Load Controller

This block is a clock-synchronous model of the write front end of a byte-wide nonvolatile memory. It samples active-low chip-enable, output-enable and write-enable strobes together with an address and data bus. Each qualifying strobe deposits one byte into a page buffer and sets that byte's loaded bit. Bytes may arrive in any order, and a byte may be overwritten while the load is open. All control inputs are treated as synchronous to `clk`.

When no new byte has been accepted for `LOAD_TIMEOUT` cycles, the load closes and a self-timed programming period of `WRITE_CYCLES` cycles begins. During the first `2**PAGE_BITS` cycles of that period, the controller walks the page offsets in ascending order. For each offset whose loaded bit is set, it presents a one-cycle write on the array port. At the end of the period the loaded bits are cleared and `busy` falls. `WRITE_CYCLES` must be at least `2**PAGE_BITS`.

Top module: `page_load_ctrl`

## Requirements
- R1: A strobe is the interval in which `ce_n` and `we_n` are both sampled low. It starts a load only if `oe_n` is high at its first cycle. Either `we_n` or `ce_n` may be the signal that falls last.
- R2: The address is taken from `addr` in the first cycle of the strobe. The data is taken from `din` in the first cycle in which the strobe is seen released. Later address changes inside the strobe have no effect.
- R3: No byte is loaded when `oe_n` is low during the strobe. No byte is loaded when `we_n` pulses while `ce_n` stays high.
- R4: Bytes of one page may be loaded in any order. Reloading an offset before programming replaces its data, and the last value written is the one kept.
- R5: During programming, only loaded offsets are written, each as a single `arr_we` cycle. Writes go in ascending offset order with `arr_addr` = {page, offset}, and no other address of the page is written.
- R6: Programming starts `LOAD_TIMEOUT` cycles after the last accepted byte. Each accepted byte restarts this window.
- R7: `busy` rises in the cycle after the first byte is accepted. It stays high until `LOAD_TIMEOUT + WRITE_CYCLES` cycles after the last accepted byte, then falls.
- R8: During an open load, a strobe whose `addr[ADDR_W-1:PAGE_BITS]` differs from the page of the first byte is ignored.
- R9: Strobes that complete while programming is in progress are ignored.
- R10: The loaded mask is cleared when programming ends, so a later load writes only its own bytes.
- R11: After reset, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low blocks writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; upper bits select the page |
| din | input | DATA_W | Write data |
| busy | output | 1 | Load or programming in progress |
| arr_we | output | 1 | Array write strobe, one cycle per byte |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
Loads are driven with write-enable-controlled strobes and with chip-enable-controlled strobes, which shows that the address is captured at whichever edge comes last. A scattered page load with a reloaded offset tells ascending-order commit and last-value-wins apart from arrival-order commit. Blocked strobes, foreign-page strobes and strobes issued during programming must produce no array write. Counting `busy` cycles for one-byte and two-byte loads separates the timeout restart from a fixed window.

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 6,
  parameter int LOAD_TIMEOUT = 15000,
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int PG_W    = ADDR_W - PAGE_BITS;
  localparam int TMAX    = (LOAD_TIMEOUT > WRITE_CYCLES) ? LOAD_TIMEOUT : WRITE_CYCLES;
  localparam int TW      = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                 st;
  logic                strb_q, armed;
  logic [ADDR_W-1:0]   alat;
  logic [PG_W-1:0]     page_q;
  logic [PAGE_SZ-1:0]  valid;
  logic [DATA_W-1:0]   pbuf [PAGE_SZ];
  logic [TW-1:0]       tmr;
  logic [PAGE_BITS-1:0] poff;

  wire strb     = !ce_n && !we_n;
  wire start    = strb && !strb_q && oe_n && (st != S_PROG);
  wire same_pg  = alat[ADDR_W-1:PAGE_BITS] == page_q;
  wire accept   = armed && !strb &&
                  ((st == S_IDLE) || ((st == S_LOAD) && same_pg));
  wire [PAGE_BITS-1:0] aoff = alat[PAGE_BITS-1:0];
  wire load_end = (st == S_LOAD) && !accept && (tmr == TW'(LOAD_TIMEOUT - 1));
  wire prog_end = (st == S_PROG) && (tmr == TW'(WRITE_CYCLES - 1));

  assign poff     = tmr[PAGE_BITS-1:0];
  assign busy     = (st != S_IDLE);
  assign arr_we   = (st == S_PROG) && (tmr < TW'(PAGE_SZ)) && valid[poff];
  assign arr_addr = {page_q, poff};
  assign arr_data = pbuf[poff];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      armed  <= 1'b0;
      alat   <= '0;
    end else begin
      strb_q <= strb;
      if (start) begin
        armed <= 1'b1;
        alat  <= addr;
      end else if (!strb || !oe_n) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      page_q <= '0;
      valid  <= '0;
    end else begin
      if (accept) begin
        valid[aoff] <= 1'b1;
        tmr         <= '0;
        st          <= S_LOAD;
        if (st == S_IDLE) page_q <= alat[ADDR_W-1:PAGE_BITS];
      end else if (load_end) begin
        st  <= S_PROG;
        tmr <= '0;
      end else if (prog_end) begin
        st    <= S_IDLE;
        tmr   <= '0;
        valid <= '0;
      end else if (st != S_IDLE) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pbuf[aoff] <= din;
  end

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_idle_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !arr_we);

  p_offsets_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[PAGE_BITS-1:0] > $past(arr_addr[PAGE_BITS-1:0])));

  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));

  p_mask_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (valid == '0));

  p_no_load_in_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG) |=> (st != S_LOAD));

  p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG) |-> (tmr < TW'(WRITE_CYCLES)));
endmodule

// File: tb/test_page_load_ctrl.sv
module test_page_load_ctrl;
  localparam int AW = 15, DW = 8, PB = 6, LT = 20, WC = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  always #5 clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB),
                   .LOAD_TIMEOUT(LT), .WRITE_CYCLES(WC)) i_page_load_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data));

  int checks = 0, fails = 0, busy_cyc = 0;
  string cur_req = "R11";
  logic [AW+DW-1:0] q[$];
  logic             exp_mask [64];
  logic [DW-1:0]    exp_data [64];
  logic [AW-PB-1:0] exp_page;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (arr_we) begin
      if (q.size() == 0) chk(0, {cur_req, " unexpected array write"}, {arr_addr, arr_data}, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = q.pop_front();
        chk({arr_addr, arr_data} == e, {cur_req, " array write"}, {arr_addr, arr_data}, e);
      end
    end
  end

  // kind: 0 WE-controlled, 1 CE-controlled, 2 OE held low, 3 CE held high
  task automatic strobe(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [AW-1:0] a2, input logic [DW-1:0] d2);
    @(negedge clk);
    addr = a; din = d;
    case (kind)
      1: begin we_n = 1'b0; oe_n = 1'b1; end
      2: begin ce_n = 1'b0; oe_n = 1'b0; end
      3: begin ce_n = 1'b1; oe_n = 1'b1; end
      default: begin ce_n = 1'b0; oe_n = 1'b1; end
    endcase
    @(negedge clk);
    if (kind == 1) ce_n = 1'b0; else we_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = a2; din = d2;
    @(negedge clk);
    if (kind == 1) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    strobe(0, a, d, a, d);
  endtask

  task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_page = a[AW-1:PB];
    exp_mask[a[PB-1:0]] = 1'b1;
    exp_data[a[PB-1:0]] = d;
  endtask

  task automatic commit();
    for (int i = 0; i < 64; i++) begin
      if (exp_mask[i]) q.push_back({exp_page, 6'(i), exp_data[i]});
      exp_mask[i] = 1'b0;
    end
  endtask

  task automatic settle(input string req);
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, {req, " all expected writes seen"}, q.size(), 0);
    chk(busy == 1'b0, {req, " busy released"}, busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin exp_mask[i] = 1'b0; exp_data[i] = '0; end
    exp_page = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    chk(arr_we == 1'b0, "R11 arr_we after reset", arr_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R7: single WE-controlled byte, busy length
    cur_req = "R1"; busy_cyc = 0;
    wr(15'h1234, 8'hA5);
    chk(busy == 1'b1, "R7 busy after first byte", busy, 1);
    model(15'h1234, 8'hA5); commit();
    settle("R1");
    chk(busy_cyc == LT + WC, "R7 busy length single byte", busy_cyc, LT + WC);

    // R4 R5: scattered page, reloaded offset
    cur_req = "R4"; busy_cyc = 0;
    wr(15'h0A45, 8'h11); model(15'h0A45, 8'h11);
    wr(15'h0A40, 8'h22); model(15'h0A40, 8'h22);
    wr(15'h0A7F, 8'h33); model(15'h0A7F, 8'h33);
    wr(15'h0A45, 8'h44); model(15'h0A45, 8'h44);
    commit();
    settle("R5");
    chk(busy_cyc == 18 + LT + WC, "R6 timeout restarts on each byte", busy_cyc, 18 + LT + WC);

    // R1 R2: CE-controlled strobe, address moves and data changes mid-strobe
    cur_req = "R2"; busy_cyc = 0;
    strobe(1, 15'h2001, 8'h01, 15'h3FC2, 8'h9C);
    model(15'h2001, 8'h9C); commit();
    settle("R2");
    chk(busy_cyc == LT + WC, "R1 CE-controlled strobe accepted", busy_cyc, LT + WC);

    // R3: blocked strobes
    cur_req = "R3"; busy_cyc = 0;
    strobe(2, 15'h0100, 8'h77, 15'h0100, 8'h77);
    strobe(3, 15'h0101, 8'h78, 15'h0101, 8'h78);
    repeat (LT + WC + 10) @(negedge clk);
    chk(busy_cyc == 0, "R3 blocked strobes leave busy low", busy_cyc, 0);
    chk(q.size() == 0, "R3 no pending writes", q.size(), 0);

    // R6: two bytes, window restarted by second byte
    cur_req = "R6"; busy_cyc = 0;
    wr(15'h4005, 8'h5A); model(15'h4005, 8'h5A);
    wr(15'h4006, 8'h5B); model(15'h4006, 8'h5B);
    commit();
    settle("R6");
    chk(busy_cyc == 6 + LT + WC, "R6 busy length two bytes", busy_cyc, 6 + LT + WC);

    // R8: foreign page ignored during load
    cur_req = "R8";
    wr(15'h1041, 8'hC1); model(15'h1041, 8'hC1);
    wr(15'h2082, 8'hC2);
    commit();
    settle("R8");

    // R9 R10: strobe during programming ignored, mask cleared afterwards
    cur_req = "R9"; busy_cyc = 0;
    wr(15'h0C10, 8'hE0); model(15'h0C10, 8'hE0);
    repeat (LT + 5) @(negedge clk);
    wr(15'h0C11, 8'hE1);
    commit();
    settle("R9");
    chk(busy_cyc == LT + WC, "R9 programming not extended", busy_cyc, LT + WC);
    cur_req = "R10";
    wr(15'h0C12, 8'hE2); model(15'h0C12, 8'hE2);
    commit();
    settle("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule